// File: doc/BRIEF.md
# Dual-Priority Ready-Queue Scheduler

This block chooses which process runs next on a processor that supports two priority levels. A process is identified by a descriptor: its word-aligned workspace address, with the lowest bit giving the priority. Ready processes wait in one of two first-in-first-out queues, one per priority. Each queue is a linked list. The block holds a head register and a tail register for each list. The "next" link of each waiting process is kept in a small internal memory, in the word two positions below that process's workspace word.

The surrounding processor tells the block four things:
- a process has become ready (the enqueue port);
- the running process has stopped or blocked (`desched`);
- the low-priority timeslice has elapsed (`tick`);
- the running process has reached a point where it may be switched out (`dpoint`).

The block keeps the running descriptor on its outputs. A high-priority arrival interrupts a running low-priority process. The interrupted process is held aside and resumes as soon as no high-priority work is left. An expired low-priority process is switched out at its next switch point and goes to the tail of the low queue.

Top module: `proc_ready_sched`

## Requirements
- R1: After reset `run_valid` is 0, `run_desc` is 0 and `busy` is 0.
- R2: Descriptor format: bit 0 gives the priority (0 = high, 1 = low), bit 1 is 0, and the value 0 is reserved to mean "no process". Within one priority, processes are dispatched in the order they were enqueued. Each queued process's link is stored at word index `desc[DW-1:2] - 2`.
- R3: Enqueueing into an empty queue makes that descriptor both head and tail. When nothing is running, the first ready process is dispatched without any other stimulus.
- R4: When `desched` is pulsed, the next process is taken in this order: the head of the high queue, then a low process that was interrupted, then the head of the low queue.
- R5: While a low process runs, a non-empty high queue makes the block switch to the high head. The interrupted low process resumes before any queued low process.
- R6: A `tick` while a low process runs marks its slice as expired. A later `dpoint` then appends that process to the tail of the low queue and dispatches the next process.
- R7: Three cases have no effect on the running process:
  - a `tick` while a high process runs;
  - a `dpoint` with no prior expiry;
  - a `tick` and a `dpoint` in the same cycle.
- R8: An accepted enqueue keeps `busy` high for exactly two cycles (link write, then tail update). `enq_valid` is ignored while `busy` is high.
- R9: A `desched` with both queues empty and no interrupted process leaves `run_valid` at 0 and `run_desc` at 0.
- R10: An enqueue accepted in the same cycle as a `desched` completes before the new process is chosen, so a high arrival in that cycle is the one dispatched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Offer a ready descriptor; accepted when `busy` is 0 |
| enq_desc | input | DW | Descriptor to enqueue |
| busy | output | 1 | An enqueue or switch is in progress |
| desched | input | 1 | Running process has stopped or blocked (pulse) |
| tick | input | 1 | Low-priority timeslice elapsed (pulse) |
| dpoint | input | 1 | Running process is at a switch point (pulse) |
| run_desc | output | DW | Descriptor of the running process, 0 when idle |
| run_valid | output | 1 | A process is running |

## Verification
Two pairs of events can fall in the same cycle, and each is provoked deliberately.

The first pair is an enqueue and a deschedule. The bench raises `enq_valid` carrying a high descriptor together with `desched` while a low process runs. It then judges that the high arrival, not an idle state or the old queue head, becomes the running process.

The second pair is slice expiry and a switch point. The bench raises `tick` and `dpoint` together. It judges that no yield happens on that cycle, and that a later lone `dpoint` does switch to the next queued low process.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINK = 2'd1,
    ST_BACK = 2'd2
  } sched_st_e;
endpackage

// File: rtl/sched_link_ram.sv
module sched_link_ram #(
  parameter int AW = 8,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sched_ready_q.sv
module sched_ready_q #(
  parameter int            DW      = 10,
  parameter logic [DW-1:0] NOTPROC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_front,
  input  logic [DW-1:0] front_d,
  input  logic          ld_back,
  input  logic [DW-1:0] back_d,
  output logic [DW-1:0] front_o,
  output logic [DW-1:0] back_o,
  output logic          empty_o
);
  logic [DW-1:0] front_q, front_n;
  logic [DW-1:0] back_q,  back_n;

  always_comb begin
    front_n = front_q;
    back_n  = back_q;
    if (ld_front) front_n = front_d;
    if (ld_back)  back_n  = back_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_q <= NOTPROC;
      back_q  <= NOTPROC;
    end else begin
      front_q <= front_n;
      back_q  <= back_n;
    end
  end

  assign front_o = front_q;
  assign back_o  = back_q;
  assign empty_o = (front_q == NOTPROC);

  AST_FRONT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_o |-> (front_q[1] == 1'b0)); // R2
endmodule

// File: rtl/proc_ready_sched.sv
module proc_ready_sched
  import sched_pkg::*;
#(
  parameter int DW       = 10,
  parameter int LINK_OFS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic [DW-1:0] enq_desc,
  output logic          busy,
  input  logic          desched,
  input  logic          tick,
  input  logic          dpoint,
  output logic [DW-1:0] run_desc,
  output logic          run_valid
);
  localparam int            AW      = DW - 2;
  localparam int            NQ      = 2;
  localparam logic [DW-1:0] NOTPROC = '0;

  function automatic logic [AW-1:0] link_of(input logic [DW-1:0] d);
    return d[DW-1:2] - AW'(LINK_OFS);
  endfunction

  sched_st_e     st_q, st_d;
  logic [DW-1:0] cur_q, cur_d;
  logic [DW-1:0] park_q, park_d;
  logic [DW-1:0] app_q, app_d;
  logic          slice_q, slice_d;
  logic          pyield_q, pyield_d;
  logic          psw_q, psw_d;

  logic [NQ-1:0][DW-1:0] fr, bk;
  logic [NQ-1:0]         emp, ld_f, ld_b;
  logic [DW-1:0]         front_d, back_d;

  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  logic          pop_sel, cur_low, enq_fire, cur_ld, hi_empty, app_pri;
  logic [DW-1:0] pop_next;

  genvar gi;
  generate
    for (gi = 0; gi < NQ; gi++) begin : g_q
      sched_ready_q #(.DW(DW), .NOTPROC(NOTPROC)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_front(ld_f[gi]),
        .front_d (front_d),
        .ld_back (ld_b[gi]),
        .back_d  (back_d),
        .front_o (fr[gi]),
        .back_o  (bk[gi]),
        .empty_o (emp[gi])
      );
    end
  endgenerate

  sched_link_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  assign run_valid = (cur_q != NOTPROC);
  assign run_desc  = cur_q;
  assign cur_low   = run_valid && cur_q[0];
  assign hi_empty  = emp[0];
  assign busy      = (st_q != ST_IDLE) || pyield_q || psw_q;
  assign enq_fire  = enq_valid && !busy;
  assign pop_sel   = emp[0];
  assign ram_raddr = link_of(fr[pop_sel]);
  assign pop_next  = (fr[pop_sel] == bk[pop_sel]) ? NOTPROC : ram_rdata;
  assign app_pri   = app_q[0];

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    park_d    = park_q;
    app_d     = app_q;
    pyield_d  = pyield_q;
    psw_d     = psw_q;
    slice_d   = slice_q;
    ld_f      = '0;
    ld_b      = '0;
    front_d   = pop_next;
    back_d    = app_q;
    ram_we    = 1'b0;
    ram_waddr = link_of(bk[app_pri]);
    ram_wdata = app_q;
    cur_ld    = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (pyield_q) begin
          app_d    = cur_q;
          st_d     = ST_LINK;
          pyield_d = 1'b0;
          psw_d    = 1'b1;
        end else if (psw_q) begin
          psw_d  = 1'b0;
          cur_ld = 1'b1;
          if (!emp[0]) begin
            ld_f[0] = 1'b1;
            cur_d   = fr[0];
          end else if (park_q != NOTPROC) begin
            cur_d  = park_q;
            park_d = NOTPROC;
          end else if (!emp[1]) begin
            ld_f[1] = 1'b1;
            cur_d   = fr[1];
          end else begin
            cur_d = NOTPROC;
          end
        end else if (enq_fire) begin
          app_d = enq_desc;
          st_d  = ST_LINK;
        end else if (!run_valid && (!emp[0] || !emp[1])) begin
          cur_ld         = 1'b1;
          ld_f[pop_sel]  = 1'b1;
          cur_d          = fr[pop_sel];
        end else if (cur_low && !emp[0]) begin
          cur_ld  = 1'b1;
          park_d  = cur_q;
          ld_f[0] = 1'b1;
          cur_d   = fr[0];
        end
      end
      ST_LINK: begin
        if (emp[app_pri]) begin
          ld_f[app_pri] = 1'b1;
          front_d       = app_q;
        end else begin
          ram_we = 1'b1;
        end
        st_d = ST_BACK;
      end
      ST_BACK: begin
        ld_b[app_pri] = 1'b1;
        st_d          = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    if (desched && run_valid) psw_d = 1'b1;
    if (dpoint && slice_q && cur_low && !psw_q && !pyield_q) pyield_d = 1'b1;

    if (cur_ld)                slice_d = 1'b0;
    else if (tick && cur_low)  slice_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_q    <= NOTPROC;
      park_q   <= NOTPROC;
      app_q    <= NOTPROC;
      slice_q  <= 1'b0;
      pyield_q <= 1'b0;
      psw_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_q    <= cur_d;
      park_q   <= park_d;
      app_q    <= app_d;
      slice_q  <= slice_d;
      pyield_q <= pyield_d;
      psw_q    <= psw_d;
    end
  end

  AST_ENQ_TWO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LINK) |=> (st_q == ST_BACK)); // R8
  AST_RUN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> ($past(st_q) == ST_IDLE)); // R8
  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && psw_q && !pyield_q && !hi_empty) |=> (run_valid && !run_desc[0])); // R4
  AST_PREEMPT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !pyield_q && !psw_q && !enq_fire && cur_low && !hi_empty)
      |=> !run_desc[0]); // R5
  AST_YIELD_AT_DPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pyield_q) |-> $past(dpoint)); // R6
endmodule

// File: tb/proc_ready_sched_test.sv
`timescale 1ns/1ps
module proc_ready_sched_test;
  localparam int DW = 10;
  localparam logic [1:0] OP_ENQ = 2'd0, OP_DES = 2'd1, OP_TCK = 2'd2, OP_DPT = 2'd3;
  localparam int NV = 15;
  // {op, descriptor, expected run_desc}
  localparam logic [21:0] VEC [NV] = '{
    {OP_ENQ, 10'h0C1, 10'h0C1},
    {OP_ENQ, 10'h101, 10'h0C1},
    {OP_ENQ, 10'h141, 10'h0C1},
    {OP_TCK, 10'h000, 10'h0C1},
    {OP_DPT, 10'h000, 10'h101},
    {OP_ENQ, 10'h040, 10'h040},
    {OP_ENQ, 10'h080, 10'h040},
    {OP_TCK, 10'h000, 10'h040},
    {OP_DPT, 10'h000, 10'h040},
    {OP_DES, 10'h000, 10'h080},
    {OP_DES, 10'h000, 10'h101},
    {OP_DES, 10'h000, 10'h141},
    {OP_DPT, 10'h000, 10'h141},
    {OP_DES, 10'h000, 10'h0C1},
    {OP_DES, 10'h000, 10'h000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic enq_valid, desched, tick, dpoint;
  logic [DW-1:0] enq_desc;
  logic busy, run_valid;
  logic [DW-1:0] run_desc;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  proc_ready_sched #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_desc(enq_desc),
    .busy(busy), .desched(desched), .tick(tick), .dpoint(dpoint),
    .run_desc(run_desc), .run_valid(run_valid)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] op, input logic [DW-1:0] d);
    @(negedge clk);
    enq_valid = (op == OP_ENQ);
    enq_desc  = d;
    desched   = (op == OP_DES);
    tick      = (op == OP_TCK);
    dpoint    = (op == OP_DPT);
    @(negedge clk);
    enq_valid = 1'b0; desched = 1'b0; tick = 1'b0; dpoint = 1'b0;
    settle();
  endtask

  task automatic do_reset();
    enq_valid = 1'b0; desched = 1'b0; tick = 1'b0; dpoint = 1'b0; enq_desc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 run_valid", {9'd0, run_valid}, '0);
    chk("R1 run_desc", run_desc, '0);
    chk("R1 busy", {9'd0, busy}, '0);

    // Table walk: queue order, preemption, yield, ignored strobes, idle
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [1:0] op;
      op = VEC[i][21:20];
      case (op)
        OP_ENQ:  tag = "R3/R5 enqueue";
        OP_DES:  tag = "R2/R4/R9 deschedule";
        OP_TCK:  tag = "R7 tick";
        default: tag = "R6/R7 dpoint";
      endcase
      pulse(op, VEC[i][19:10]);
      chk($sformatf("%s step %0d", tag, i), run_desc, VEC[i][9:0]);
    end

    // R8: busy for two cycles after accept, enqueue ignored meanwhile
    do_reset();
    @(negedge clk);
    enq_valid = 1'b1; enq_desc = 10'h141;
    @(negedge clk);
    enq_desc = 10'h101;
    chk("R8 busy cycle 1", {9'd0, busy}, 10'd1);
    @(negedge clk);
    chk("R8 busy cycle 2", {9'd0, busy}, 10'd1);
    enq_valid = 1'b0;
    @(negedge clk);
    chk("R8 busy released", {9'd0, busy}, 10'd0);
    settle();
    chk("R8 first accepted", run_desc, 10'h141);
    pulse(OP_DES, '0);
    chk("R8 ignored enqueue not queued", run_desc, 10'h000);
    chk("R9 idle after empty deschedule", {9'd0, run_valid}, 10'd0);

    // R10: enqueue high together with deschedule of a running low
    do_reset();
    pulse(OP_ENQ, 10'h0C1);
    chk("R3 idle dispatch", run_desc, 10'h0C1);
    @(negedge clk);
    enq_valid = 1'b1; enq_desc = 10'h080; desched = 1'b1;
    @(negedge clk);
    enq_valid = 1'b0; desched = 1'b0;
    settle();
    chk("R10 coincident enqueue wins", run_desc, 10'h080);
    pulse(OP_DES, '0);
    chk("R9 nothing left", run_desc, 10'h000);

    // R7: tick and dpoint in the same cycle do not yield; later dpoint does
    do_reset();
    pulse(OP_ENQ, 10'h0C1);
    pulse(OP_ENQ, 10'h101);
    @(negedge clk);
    tick = 1'b1; dpoint = 1'b1;
    @(negedge clk);
    tick = 1'b0; dpoint = 1'b0;
    settle();
    chk("R7 same-cycle tick and dpoint", run_desc, 10'h0C1);
    pulse(OP_DPT, '0);
    chk("R6 yield after earlier expiry", run_desc, 10'h101);
    pulse(OP_DES, '0);
    chk("R6 yielded process at tail", run_desc, 10'h0C1);

    // R6: single low process yields to itself
    pulse(OP_TCK, '0);
    pulse(OP_DPT, '0);
    chk("R6 lone low re-dispatched", run_desc, 10'h0C1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule